// File: doc/BRIEF.md
# Memory-Controller Event Counter Bank

This block gives a memory controller a small bank of free-running 32-bit event counters that software programs and reads through a 32-bit register port. One control word, shared by every counter, holds a separate 5-bit event selector for each counter. Each selector lives in its own byte lane of that word. A counter whose selector is zero is stopped. A nonzero selector picks what the counter counts: every clock cycle, write-transaction strobes, read-transaction strobes, or data-transfer beats.

Because the selectors share one word, software stops or starts a single counter with a read-modify-write of the control word. Only the targeted field changes, so the other counters keep running. Each counter also has its own data register. Reading it returns the running count. Writing it loads the written value, so writing zero clears the counter. Scaling for channel count and conversion of beats to bytes are left to software.

Top module: `mc_event_counter_bank`

## Requirements
- R1: After reset the control word and all four counters read zero.
- R2: The control word sits at byte address 0x234. Counter n's selector occupies bits 8n+1 to 8n+5. Every other bit of that word ignores writes and reads zero, so writing 0xFFFFFFFF reads back 0x3E3E3E3E.
- R3: Counter n's value reads at byte address 0x240 + 12n, which gives 0x240, 0x24C, 0x258 and 0x264.
- R4: A selector of zero holds its counter at its current value, while counters with nonzero selectors keep counting.
- R5: Selector 0x01 adds one on every clock edge.
- R6: Selector 0x0B adds one on each edge where the write strobe is high. Selector 0x0F does the same for the read strobe.
- R7: Selector 0x0D adds the 3-bit beat input on each edge. Beat values above 4 count as 4.
- R8: Any nonzero selector other than 0x01, 0x0B, 0x0D and 0x0F counts nothing.
- R9: A write to a data register loads the written value at that edge and replaces that edge's increment. Writing zero clears the counter.
- R10: Counters wrap modulo 2^32.
- R11: Reads of any other address return zero, and writes to any other address change no state.
- R12: A control write takes effect at its own edge. The increment at that edge still uses the old selector, and the new selector governs from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_wr_stb | input | 1 | One write transaction this cycle |
| ev_rd_stb | input | 1 | One read transaction this cycle |
| ev_beats | input | 3 | Data-transfer beats this cycle |

## Verification
The bench builds the block with its default parameters: four 32-bit counters, 5-bit selectors in 8-bit lanes, and a 12-byte data stride. A full 2^32 count is out of reach in simulation, so the wrap is reached by preloading a counter through its data register to just below the limit. The default 3-bit beat input allows values from 5 to 7, which brings the clamp to 4 into reach. Because the control word is wide, the bench can write ones into every reserved bit and confirm that none of them sticks.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_OFF    = 5'h00;
  localparam logic [SEL_W-1:0] SEL_CYCLES = 5'h01;
  localparam logic [SEL_W-1:0] SEL_WRITES = 5'h0B;
  localparam logic [SEL_W-1:0] SEL_BEATS  = 5'h0D;
  localparam logic [SEL_W-1:0] SEL_READS  = 5'h0F;
endpackage

// File: rtl/ecb_rst_sync.sv
module ecb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/ecb_ctrl_reg.sv
module ecb_ctrl_reg #(
  parameter int              REG_W = 32,
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] d;

  always_comb begin
    d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/ecb_event_sel.sv
module ecb_event_sel
  import ecb_pkg::*;
#(
  parameter int BEAT_W    = 3,
  parameter int MAX_BEATS = 4
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BEAT_W-1:0] beats,
  output logic [BEAT_W-1:0] inc
);
  localparam logic [BEAT_W-1:0] BEAT_CAP = BEAT_W'(MAX_BEATS);
  logic [BEAT_W-1:0] beats_cap;

  always_comb begin
    beats_cap = (beats > BEAT_CAP) ? BEAT_CAP : beats;
    unique case (sel)
      SEL_CYCLES: inc = BEAT_W'(1);
      SEL_WRITES: inc = BEAT_W'(wr_stb);
      SEL_READS:  inc = BEAT_W'(rd_stb);
      SEL_BEATS:  inc = beats_cap;
      default:    inc = '0;
    endcase
  end
endmodule

// File: rtl/ecb_counter.sv
module ecb_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W-1:0] d;
  logic             en;

  always_comb begin
    en = ld | (inc != '0);
    if (ld) d = ld_val;
    else    d = q + CNT_W'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/mc_event_counter_bank.sv
module mc_event_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 32,
  parameter int REG_W       = 32,
  parameter int ADDR_W      = 12,
  parameter int LANE_W      = 8,
  parameter int SEL_LSB     = 1,
  parameter int CTRL_ADDR   = 'h234,
  parameter int DATA_BASE   = 'h240,
  parameter int DATA_STRIDE = 12,
  parameter int BEAT_W      = 3,
  parameter int MAX_BEATS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_wr_stb,
  input  logic              ev_rd_stb,
  input  logic [BEAT_W-1:0] ev_beats
);
  function automatic logic [REG_W-1:0] sel_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) m[i*LANE_W+SEL_LSB +: SEL_W] = '1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] CTRL_MASK = sel_mask();

  logic                          rst_sync_n;
  logic                          ctrl_hit;
  logic [NUM_CNT-1:0]            data_hit;
  logic [REG_W-1:0]              ctrl_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  ecb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign ctrl_hit = (reg_addr == ADDR_W'(CTRL_ADDR));

  ecb_ctrl_reg #(.REG_W(REG_W), .MASK(CTRL_MASK)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr & ctrl_hit),
    .wdata(reg_wdata), .q(ctrl_q)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic [BEAT_W-1:0] inc;

    assign data_hit[n] = (reg_addr == ADDR_W'(DATA_BASE + n*DATA_STRIDE));

    ecb_event_sel #(.BEAT_W(BEAT_W), .MAX_BEATS(MAX_BEATS)) u_sel (
      .sel(ctrl_q[n*LANE_W+SEL_LSB +: SEL_W]),
      .wr_stb(ev_wr_stb), .rd_stb(ev_rd_stb), .beats(ev_beats), .inc(inc)
    );

    ecb_counter #(.CNT_W(CNT_W), .INC_W(BEAT_W)) u_cnt (
      .clk(clk), .rst_n(rst_sync_n), .ld(reg_wr & data_hit[n]),
      .ld_val(reg_wdata[CNT_W-1:0]), .inc(inc), .q(cnt_q[n])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit) reg_rdata = ctrl_q;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (data_hit[n]) reg_rdata = REG_W'(cnt_q[n]);
    end
  end
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker
  import ecb_pkg::*;
#(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 32,
  parameter int REG_W       = 32,
  parameter int ADDR_W      = 12,
  parameter int LANE_W      = 8,
  parameter int SEL_LSB     = 1,
  parameter int CTRL_ADDR   = 'h234,
  parameter int DATA_BASE   = 'h240,
  parameter int DATA_STRIDE = 12,
  parameter int MAX_BEATS   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [REG_W-1:0]              reg_wdata,
  input logic [REG_W-1:0]              reg_rdata,
  input logic [REG_W-1:0]              ctrl_q,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
  function automatic logic [REG_W-1:0] sel_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) m[i*LANE_W+SEL_LSB +: SEL_W] = '1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] CTRL_MASK = sel_mask();

  logic [NUM_CNT-1:0] hit;
  logic               mapped;

  always_comb begin
    mapped = (reg_addr == ADDR_W'(CTRL_ADDR));
    for (int n = 0; n < NUM_CNT; n++) begin
      hit[n] = (reg_addr == ADDR_W'(DATA_BASE + n*DATA_STRIDE));
      mapped = mapped | hit[n];
    end
  end

  // R2: reserved control bits never reach the read port
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTRL_ADDR)) |-> ((reg_rdata & ~CTRL_MASK) == '0));

  // R11: unmapped reads return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0));

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
    logic [SEL_W-1:0] sel;
    assign sel = ctrl_q[n*LANE_W+SEL_LSB +: SEL_W];

    // R9: data write loads the written value
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && hit[n]) |=> (cnt_q[n] == $past(reg_wdata[CNT_W-1:0])));

    // R4: zero selector holds the counter
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel == SEL_OFF) && !(reg_wr && hit[n])) |=> $stable(cnt_q[n]));

    // R5: cycle selector adds one per edge
    a_r5_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel == SEL_CYCLES) && !(reg_wr && hit[n])) |=>
        (cnt_q[n] == $past(cnt_q[n]) + CNT_W'(1)));

    // R7: no edge adds more than the beat cap
    a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && hit[n]) |=> ((cnt_q[n] - $past(cnt_q[n])) <= CNT_W'(MAX_BEATS)));
  end
endmodule

bind mc_event_counter_bank ecb_checker #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
  .LANE_W(LANE_W), .SEL_LSB(SEL_LSB), .CTRL_ADDR(CTRL_ADDR),
  .DATA_BASE(DATA_BASE), .DATA_STRIDE(DATA_STRIDE), .MAX_BEATS(MAX_BEATS)
) u_ecb_checker (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q), .cnt_q(cnt_q)
);

// File: tb/tb_mc_event_counter_bank.sv
module tb_mc_event_counter_bank;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ev_wr_stb;
  logic        ev_rd_stb;
  logic [2:0]  ev_beats;

  int total = 0;
  int bad = 0;
  string tag_ovr = "";

  mc_event_counter_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_wr_stb(ev_wr_stb),
    .ev_rd_stb(ev_rd_stb), .ev_beats(ev_beats)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_ctrl;
  logic [31:0] m_cnt [4];

  function automatic logic [11:0] daddr(int n);
    return 12'(32'h240 + 12*n);
  endfunction

  function automatic logic [4:0] msel(int n);
    return 5'((m_ctrl >> (8*n + 1)) & 32'h1F);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int n = 0; n < 4; n++) m_cnt[n] = 0;
    end else begin
      logic [31:0] nxt [4];
      for (int n = 0; n < 4; n++) begin
        int add;
        case (msel(n))
          5'h01:   add = 1;
          5'h0B:   add = ev_wr_stb ? 1 : 0;
          5'h0F:   add = ev_rd_stb ? 1 : 0;
          5'h0D:   add = (ev_beats > 3'd4) ? 4 : int'(ev_beats);
          default: add = 0;
        endcase
        nxt[n] = m_cnt[n] + 32'(add);
        if (reg_wr && reg_addr == daddr(n)) nxt[n] = reg_wdata;
      end
      if (reg_wr && reg_addr == 12'h234) m_ctrl = reg_wdata & 32'h3E3E3E3E;
      for (int n = 0; n < 4; n++) m_cnt[n] = nxt[n];
    end
  end

  function automatic logic [31:0] exp_read(logic [11:0] a);
    if (a == 12'h234) return m_ctrl;
    for (int n = 0; n < 4; n++) if (a == daddr(n)) return m_cnt[n];
    return 0;
  endfunction

  function automatic string req_of(logic [11:0] a);
    if (tag_ovr != "") return tag_ovr;
    if (a == 12'h234) return "R2";
    for (int n = 0; n < 4; n++) begin
      if (a == daddr(n)) begin
        case (msel(n))
          5'h00:        return "R4";
          5'h01:        return "R5";
          5'h0B, 5'h0F: return "R6";
          5'h0D:        return "R7";
          default:      return "R8";
        endcase
      end
    end
    return "R11";
  endfunction

  task automatic do_check();
    logic [31:0] e;
    e = exp_read(reg_addr);
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req_of(reg_addr),
               reg_addr, reg_rdata, e);
    end
  endtask

  // check the current read, then drive the next cycle's inputs
  task automatic cyc(bit wr, logic [11:0] a, logic [31:0] wd,
                     bit ws, bit rs, logic [2:0] bt);
    @(negedge clk);
    do_check();
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    ev_wr_stb = ws; ev_rd_stb = rs; ev_beats = bt;
  endtask

  task automatic rd(logic [11:0] a);
    cyc(0, a, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cyc(1, a, d, 0, 0, 0);
  endtask

  task automatic run_random(int cycles);
    for (int i = 0; i < cycles; i++) begin
      logic [11:0] a;
      case (i % 6)
        0: a = 12'h234;
        5: a = 12'h238;
        default: a = daddr((i % 6) - 1);
      endcase
      cyc(0, a, 0, 1'($urandom), 1'($urandom), 3'($urandom));
    end
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ev_wr_stb = 0; ev_rd_stb = 0; ev_beats = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    tag_ovr = "R1";
    rd(12'h234);
    for (int n = 0; n < 4; n++) rd(daddr(n));
    rd(12'h234);
    tag_ovr = "";

    // R2: reserved bits dropped
    wr(12'h234, 32'hFFFF_FFFF);
    tag_ovr = "R2";
    rd(12'h234);
    rd(12'h234);
    wr(12'h234, 32'h0);
    rd(12'h234);
    tag_ovr = "";

    // R9: clear counters, then preload one and clear it again
    for (int n = 0; n < 4; n++) wr(daddr(n), 32'h0);
    tag_ovr = "R9";
    wr(daddr(2), 32'h1234_5678);
    rd(daddr(2));
    wr(daddr(2), 32'h0);
    rd(daddr(2));
    rd(daddr(2));
    tag_ovr = "";

    // all four selectors active: cycles, writes, beats, reads
    wr(12'h234, 32'h1E1A_1602);
    run_random(300);

    // R3: data register addresses
    tag_ovr = "R3";
    for (int n = 0; n < 4; n++) rd(daddr(n));
    rd(daddr(3));
    tag_ovr = "";

    // R4: stop counter 1 only
    wr(12'h234, 32'h1E1A_0002);
    run_random(120);

    // R8: unknown selector on counter 2
    wr(12'h234, 32'h1E0A_0002);
    run_random(60);

    // R9 with events active: write beats counter while beats arrive
    wr(12'h234, 32'h1E1A_0002);
    cyc(0, daddr(2), 0, 0, 0, 3'd7);
    tag_ovr = "R9";
    cyc(1, daddr(2), 32'h0, 0, 0, 3'd3);
    cyc(0, daddr(2), 0, 0, 0, 3'd0);
    rd(daddr(2));
    tag_ovr = "";

    // R10: wrap of the cycle counter
    tag_ovr = "R10";
    wr(daddr(0), 32'hFFFF_FFFE);
    rd(daddr(0));
    rd(daddr(0));
    rd(daddr(0));
    rd(daddr(0));
    tag_ovr = "";

    // R12: switch counter 3 to cycle counting while reads keep coming
    tag_ovr = "R12";
    wr(daddr(3), 32'h0);
    cyc(1, 12'h234, 32'h021A_0002, 0, 1, 0);
    cyc(0, daddr(3), 0, 0, 1, 0);
    cyc(0, daddr(3), 0, 0, 1, 0);
    rd(daddr(3));
    tag_ovr = "";

    // R11: unmapped write changes nothing
    tag_ovr = "R11";
    wr(12'h238, 32'hFFFF_FFFF);
    wr(12'h244, 32'hFFFF_FFFF);
    rd(12'h238);
    rd(12'h234);
    for (int n = 0; n < 4; n++) rd(daddr(n));
    rd(12'h000);
    tag_ovr = "";

    run_random(60);
    @(negedge clk);
    do_check();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule